// File: doc/BRIEF.md
# Sequential Fixed-Point Log Divider

This block divides an unsigned 16-bit fixed-point value (4 integer bits above 12 fraction bits) by a small unsigned integer n of 4 bits. It is meant to sit between a binary-logarithm stage and an antilogarithm stage: dividing log2(x) by n and taking the antilog gives the n-th root of x. The quotient keeps the same 4.12 format as the dividend, so any rounding loss is a truncation of the lowest fraction bits. Because the format is fixed, the quotient is the integer quotient of the raw 16-bit words.

The divider works sequentially. A single restoring step compares a 5-bit partial remainder with n, subtracts only when the remainder is at least n, and shifts one quotient bit in. The first iteration is different: it resolves the whole 4-bit integer field of the dividend in one cycle, using a short chain of the same step cells. The next twelve iterations each bring in one fraction bit. A full division therefore takes 13 iterations and not 16.

A caller pulses `start` with the operands while `busy` is low. It then waits for the single-cycle `done` pulse and reads `quotient` and `remainder`. A zero divisor does not start the iterations. It returns at once with an all-ones quotient and raises `div_by_zero`.

Top module: `nroot_log_divider`

## Requirements
- R1: For a nonzero divisor, `quotient` at `done` equals floor(dividend / divisor), where both are read as unsigned integers (all 16 bits of the dividend).
- R2: For a nonzero divisor, `remainder` at `done` equals dividend mod divisor and is less than the divisor.
- R3: A start with a nonzero divisor is accepted at the rising edge where `start` is 1 and `busy` is 0. `busy` is then 1 for the 13 cycles after that edge, with `done` at 0. After the 13th edge that follows acceptance, `busy` is 0 and `done` is 1.
- R4: `done` is never high for two consecutive cycles.
- R5: `start` has no effect while `busy` is 1. The result of the division in progress is unchanged, and no new division starts when it ends.
- R6: A start with divisor 0 completes in the cycle after the accepting edge, with `busy` still 0. That cycle shows `done` = 1, `div_by_zero` = 1, `quotient` = 16'hFFFF and `remainder` = 0.
- R7: `div_by_zero` is 0 in the `done` cycle of every division by a nonzero divisor.
- R8: Once `done` has been seen, `quotient`, `remainder` and `div_by_zero` keep their values until the next accepted start.
- R9: After reset, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; sampled only while busy is low |
| dividend | input | 16 | 4.12 fixed-point dividend, captured at acceptance |
| divisor | input | 4 | Unsigned integer divisor n, captured at acceptance |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle pulse marking a valid result |
| div_by_zero | output | 1 | Set with done when the divisor was zero |
| quotient | output | 16 | 4.12 fixed-point quotient |
| remainder | output | 4 | Integer remainder of the division |

## Verification
Every nonzero divisor from 1 to 15 is paired with about three hundred dividends spread evenly over the 16-bit range. Added to these are the words 0, 1, 0x0FFF, 0x8000, 0xF000 and 0xFFFF. The spread values test whether the 4-bit first step and the single-bit steps join correctly. The corner words test an integer field of zero, a dividend smaller than n, and a full-scale input. Divisor 0 is tried with several dividends, to show that the dividend does not affect the fixed all-ones result. One division receives a second start with different operands in the middle of its run, which shows whether the captured operands are protected.

// File: rtl/nroot_div_pkg.sv
package nroot_div_pkg;

    // Operation chosen for the next clock edge
    typedef enum logic [2:0] {
        OP_HOLD = 3'd0,
        OP_LOAD = 3'd1,
        OP_ZERO = 3'd2,
        OP_HEAD = 3'd3,
        OP_STEP = 3'd4
    } div_op_e;

    // Number of iterations: one wide head step, then one per remaining bit
    function automatic int unsigned iter_count(input int unsigned dvd_w,
                                               input int unsigned head_w);
        return 1 + (dvd_w - head_w);
    endfunction

endpackage

// File: rtl/nroot_div_step.sv
// One restoring step: comparator, controlled subtractor and remainder selector.
module nroot_div_step #(
    parameter int DVS_W = 4
) (
    input  logic [DVS_W-1:0] rem_in,
    input  logic             bit_in,
    input  logic [DVS_W-1:0] dvs,
    output logic             q_bit,
    output logic [DVS_W-1:0] rem_out
);
    localparam int WIDE_W = DVS_W + 1;

    logic [WIDE_W-1:0] shifted;
    logic [WIDE_W-1:0] diff;
    logic              ge;

    // Partial remainder with the new bit appended; one extra bit avoids overflow
    assign shifted = {rem_in, bit_in};
    assign ge      = (shifted >= {1'b0, dvs});
    assign diff    = shifted - {1'b0, dvs};
    assign q_bit   = ge;

    // Keep the difference only when it did not go negative
    always_comb begin
        if (ge) rem_out = diff[DVS_W-1:0];
        else    rem_out = shifted[DVS_W-1:0];
    end

    // A remainder that starts below the divisor must stay below it (R2)
    always_comb begin
        if (dvs != '0 && rem_in < dvs) begin
            assert_step_rem_bound_R2: assert (rem_out < dvs);
        end
    end

endmodule

// File: rtl/nroot_div_head.sv
// Resolves the top HEAD_W dividend bits in a single cycle with a chain of steps.
module nroot_div_head #(
    parameter int HEAD_W = 4,
    parameter int DVS_W  = 4
) (
    input  logic [HEAD_W-1:0] field,
    input  logic [DVS_W-1:0]  dvs,
    output logic [HEAD_W-1:0] q_bits,
    output logic [DVS_W-1:0]  rem
);
    logic [DVS_W-1:0] chain [HEAD_W+1];

    assign chain[0] = '0;

    for (genvar g = 0; g < HEAD_W; g++) begin : g_cell
        nroot_div_step #(.DVS_W(DVS_W)) step_i (
            .rem_in  (chain[g]),
            .bit_in  (field[HEAD_W-1-g]),
            .dvs     (dvs),
            .q_bit   (q_bits[HEAD_W-1-g]),
            .rem_out (chain[g+1])
        );
    end

    assign rem = chain[HEAD_W];

endmodule

// File: rtl/nroot_log_divider.sv
module nroot_log_divider
    import nroot_div_pkg::*;
#(
    parameter int DVD_W  = 16,
    parameter int DVS_W  = 4,
    parameter int HEAD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic             div_by_zero,
    output logic [DVD_W-1:0] quotient,
    output logic [DVS_W-1:0] remainder
);
    localparam int ITER  = int'(iter_count(DVD_W, HEAD_W));
    localparam int CNT_W = $clog2(ITER);
    localparam int LOW_W = DVD_W - HEAD_W;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             dbz;
        logic [CNT_W-1:0] cnt;
        logic [DVD_W-1:0] pend;
        logic [DVS_W-1:0] dvs;
        logic [DVS_W-1:0] rem;
        logic [DVD_W-1:0] quo;
    } div_state_t;

    div_state_t s_q, s_d;
    div_op_e    op;

    logic [HEAD_W-1:0] head_q;
    logic [DVS_W-1:0]  head_r;
    logic              step_q;
    logic [DVS_W-1:0]  step_r;

    nroot_div_head #(.HEAD_W(HEAD_W), .DVS_W(DVS_W)) head_i (
        .field  (s_q.pend[DVD_W-1 -: HEAD_W]),
        .dvs    (s_q.dvs),
        .q_bits (head_q),
        .rem    (head_r)
    );

    nroot_div_step #(.DVS_W(DVS_W)) step_i (
        .rem_in  (s_q.rem),
        .bit_in  (s_q.pend[DVD_W-1]),
        .dvs     (s_q.dvs),
        .q_bit   (step_q),
        .rem_out (step_r)
    );

    // Operation select
    always_comb begin
        if (!s_q.busy) begin
            if (!start)               op = OP_HOLD;
            else if (divisor == '0)   op = OP_ZERO;
            else                      op = OP_LOAD;
        end else if (s_q.cnt == '0) begin
            op = OP_HEAD;
        end else begin
            op = OP_STEP;
        end
    end

    // Next-state computation
    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (op)
            OP_LOAD: begin
                s_d.busy = 1'b1;
                s_d.dbz  = 1'b0;
                s_d.cnt  = '0;
                s_d.pend = dividend;
                s_d.dvs  = divisor;
                s_d.rem  = '0;
                s_d.quo  = '0;
            end
            OP_ZERO: begin
                s_d.done = 1'b1;
                s_d.dbz  = 1'b1;
                s_d.cnt  = '0;
                s_d.dvs  = '0;
                s_d.rem  = '0;
                s_d.quo  = '1;
            end
            OP_HEAD: begin
                s_d.quo  = {s_q.quo[LOW_W-1:0], head_q};
                s_d.rem  = head_r;
                s_d.pend = s_q.pend << HEAD_W;
                s_d.cnt  = s_q.cnt + CNT_W'(1);
            end
            OP_STEP: begin
                s_d.quo  = {s_q.quo[DVD_W-2:0], step_q};
                s_d.rem  = step_r;
                s_d.pend = s_q.pend << 1;
                s_d.cnt  = s_q.cnt + CNT_W'(1);
                if (s_q.cnt == LAST) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                    s_d.cnt  = '0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy        = s_q.busy;
    assign done        = s_q.done;
    assign div_by_zero = s_q.dbz;
    assign quotient    = s_q.quo;
    assign remainder   = s_q.rem;

    // ---------------- assertions ----------------
    assert_last_iter_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt == LAST) |=> (done && !busy));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && start && s_q.cnt != LAST) |=> (busy && $stable(s_q.dvs)));

    assert_rem_below_n_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_by_zero) |-> (remainder < s_q.dvs));

    assert_zero_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_by_zero) |-> (quotient == '1 && remainder == '0 && !busy));

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

endmodule

// File: tb/nroot_log_divider_tb.sv
module nroot_log_divider_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] dividend = '0;
    logic [3:0]  divisor = '0;
    logic        busy, done, div_by_zero;
    logic [15:0] quotient;
    logic [3:0]  remainder;

    int n_cmp = 0;
    int n_mis = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    nroot_log_divider dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .dividend    (dividend),
        .divisor     (divisor),
        .busy        (busy),
        .done        (done),
        .div_by_zero (div_by_zero),
        .quotient    (quotient),
        .remainder   (remainder)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_mis++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_div(input logic [15:0] d, input logic [3:0] n, input bit poke);
        logic [15:0] eq;
        logic [3:0]  er;
        @(negedge clk);
        start    = 1'b1;
        dividend = d;
        divisor  = n;
        @(negedge clk);           // accepting edge has passed
        start = 1'b0;
        if (n == 4'd0) begin
            chk(done === 1'b1 && busy === 1'b0, "R6 done/busy", 32'({done, busy}), 32'h2);
            chk(div_by_zero === 1'b1, "R6 flag", 32'(div_by_zero), 32'h1);
            chk(quotient === 16'hFFFF, "R6 quotient", 32'(quotient), 32'hFFFF);
            chk(remainder === 4'd0, "R6 remainder", 32'(remainder), 32'h0);
            @(negedge clk);
            chk(done === 1'b0, "R4 zero pulse", 32'(done), 32'h0);
            chk(quotient === 16'hFFFF && div_by_zero === 1'b1, "R8 zero hold",
                32'(quotient), 32'hFFFF);
            return;
        end
        eq = 16'(int'(d) / int'(n));
        er = 4'(int'(d) % int'(n));
        chk(busy === 1'b1 && done === 1'b0, "R3 busy first", 32'({busy, done}), 32'h2);
        for (int i = 1; i < 13; i++) begin
            if (poke && i == 5) begin
                start    = 1'b1;
                dividend = ~d;
                divisor  = n ^ 4'h5;
            end
            @(negedge clk);
            start = 1'b0;
            chk(busy === 1'b1 && done === 1'b0, "R3 busy window", 32'({busy, done}), 32'h2);
        end
        @(negedge clk);
        chk(done === 1'b1 && busy === 1'b0, "R3 done after 13", 32'({done, busy}), 32'h2);
        chk(quotient === eq, poke ? "R5 quotient" : "R1 quotient", 32'(quotient), 32'(eq));
        chk(remainder === er, poke ? "R5 remainder" : "R2 remainder", 32'(remainder), 32'(er));
        chk(div_by_zero === 1'b0, "R7 flag low", 32'(div_by_zero), 32'h0);
        @(negedge clk);
        chk(done === 1'b0, "R4 single pulse", 32'(done), 32'h0);
        chk(busy === 1'b0, "R5 no restart", 32'(busy), 32'h0);
        chk(quotient === eq && remainder === er, "R8 hold",
            32'({quotient, remainder}), 32'({eq, er}));
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_cmp++;
            n_mis++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values
        chk(busy === 1'b0 && done === 1'b0 && div_by_zero === 1'b0, "R9 flags",
            32'({busy, done, div_by_zero}), 32'h0);
        chk(quotient === 16'h0 && remainder === 4'h0, "R9 data",
            32'({quotient, remainder}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: zero divisor with several dividends
        run_div(16'h0000, 4'd0, 1'b0);
        run_div(16'h1234, 4'd0, 1'b0);
        run_div(16'hFFFF, 4'd0, 1'b0);

        // R1 R2: corner dividends over all nonzero divisors
        for (int n = 1; n < 16; n++) begin
            run_div(16'h0000, 4'(n), 1'b0);
            run_div(16'h0001, 4'(n), 1'b0);
            run_div(16'h0FFF, 4'(n), 1'b0);
            run_div(16'h8000, 4'(n), 1'b0);
            run_div(16'hF000, 4'(n), 1'b0);
            run_div(16'hFFFF, 4'(n), 1'b0);
        end

        // R5: start during busy is ignored
        run_div(16'hBEEF, 4'd7, 1'b1);
        run_div(16'h4321, 4'd1, 1'b1);

        // R8: zero divide after a normal one replaces the result
        run_div(16'h7000, 4'd0, 1'b0);

        // R1 R2: spread sweep
        for (int n = 1; n < 16; n++) begin
            for (int v = 0; v < 65536; v += 211) begin
                run_div(16'(v), 4'(n), 1'b0);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

endmodule